// File: doc/BRIEF.md
# Dual-Rank DRAM Bank Timing Monitor

This block sits beside a memory controller and watches, without driving anything, a command bus shared by two ranks of DDR2-style memory. Each rank has its own active-low chip select and its own clock enable. Row strobe, column strobe, write enable, the 3-bit bank address and the 15-bit address are common to both ranks. The monitor keeps a separate table for each rank. For every one of the eight banks in a rank, the table holds the open or closed state, the last activated row and three spacing timers. Each rank also has one refresh timer.

When a command breaks a bank-state rule or arrives too soon after an earlier command, the monitor sets a sticky flag and stores a 4-bit code that says why. The code always describes the first offending command. It stays until a synchronous clear input is pulsed. All spacing limits are parameters counted in controller clock cycles. The defaults match a 2.5 ns clock: 5 cycles from activate to access, 5 cycles of precharge recovery, 22 cycles between activates to the same bank, and 79 cycles of refresh recovery.

Top module: `rank_bank_monitor`

## Requirements
- R1: While `rst` is high on a clock edge, the monitor closes every bank in both ranks, zeroes every spacing timer and clears the flag. After that edge `viol_flag` is 0 and `viol_code` is 0.
- R2: A command is decoded from {ras_n,cas_n,we_n} as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load and 111 no-operation. A command has no effect on a rank whose `cs_n` bit is high.
- R3: The following are state violations. Each still updates the table. An activate to an open bank gives code 3. A read or write to a closed bank gives code 4. A refresh while any bank of that rank is open gives code 5.
- R4: A precharge with addr[10] low closes only the bank given by `ba`. A precharge with addr[10] high closes all eight banks of the selected rank. Each bank the precharge addresses starts its recovery timer.
- R5: A read or write to an open bank with addr[10] high closes that bank once the access is done.
- R6: A read or write issued fewer than T_RCD cycles after the activate of its bank gives code 7.
- R7: An activate issued fewer than T_RP cycles after a precharge that addressed the same bank gives code 8.
- R8: An activate issued fewer than T_RC cycles after the previous activate of the same bank gives code 9.
- R9: Any command other than no-operation sent to a rank fewer than T_RFC cycles after a refresh of that rank gives code 6.
- R10: A cycle in which more than one `cs_n` bit is low gives code 1. Neither rank's table is updated by that command.
- R11: A command other than no-operation sent to a rank whose `cke` bit is low gives code 2. The command is not applied. A no-operation in that state is not a violation.
- R12: The flag and code are set by the first violating cycle and then hold. If several violations occur in one cycle, the lowest code is stored. A `viol_clr` pulse clears both on the next edge, and it also drops any violation in that same cycle.
- R13: Each rank has its own bank table and timers. A command to one rank never changes the state or the timing limits of the other rank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all bus signals are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| viol_clr | input | 1 | Synchronous clear of the flag and code |
| cs_n | input | 2 | Per-rank chip select, active low |
| cke | input | 2 | Per-rank clock enable |
| ras_n | input | 1 | Row strobe, active low, shared |
| cas_n | input | 1 | Column strobe, active low, shared |
| we_n | input | 1 | Write enable, active low, shared |
| ba | input | 3 | Bank address, shared |
| addr | input | 15 | Row address; bit 10 selects all-bank precharge or auto precharge |
| viol_flag | output | 1 | Sticky violation indication |
| viol_code | output | 4 | Code of the first violation (0 when none) |

## Verification
The hardest case to reach from the ports is an internal state that can only be seen through a later command, such as a bank closed by auto precharge, by a precharge-all or by an ignored chip select. The stimulus therefore follows each such event with a probing read or refresh, spaced to clear every timer, so that the resulting code exposes the hidden bank state. Timing windows are probed one cycle short of each limit and exactly at the limit. Commands that break two rules at once check the priority order.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    localparam int NCODE = 10;

    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_RSV = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [3:0] {
        V_NONE       = 4'd0,
        V_MULTI_CS   = 4'd1,
        V_POWER      = 4'd2,
        V_ACT_OPEN   = 4'd3,
        V_ACC_CLOSED = 4'd4,
        V_REF_OPEN   = 4'd5,
        V_RFC        = 4'd6,
        V_RCD        = 4'd7,
        V_RP         = 4'd8,
        V_RC         = 4'd9
    } viol_e;

    typedef struct packed {
        logic power;
        logic act_open;
        logic acc_closed;
        logic ref_open;
        logic rfc;
        logic rcd;
        logic rp;
        logic rc;
    } rank_err_t;

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

    // lowest set code wins
    function automatic viol_e pick_first(input logic [NCODE-1:1] hits);
        viol_e r;
        r = V_NONE;
        for (int i = NCODE - 1; i >= 1; i--) begin
            if (hits[i]) r = viol_e'(i[3:0]);
        end
        return r;
    endfunction

endpackage

// File: rtl/rbm_cmd_decode.sv
module rbm_cmd_decode
    import rbm_pkg::*;
#(
    parameter int N_RANK = 2
) (
    input  logic [N_RANK-1:0] cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    output cmd_e              cmd,
    output logic [N_RANK-1:0] rank_sel,
    output logic              multi_cs
);
    logic [N_RANK-1:0] low;
    int unsigned       n_low;

    always_comb begin
        low   = ~cs_n;
        n_low = 0;
        for (int r = 0; r < N_RANK; r++) n_low += {31'd0, low[r]};
        multi_cs = (n_low > 1);
        rank_sel = multi_cs ? '0 : low;
        cmd      = cmd_e'({ras_n, cas_n, we_n});
    end
endmodule

// File: rtl/rbm_rank_tracker.sv
module rbm_rank_tracker
    import rbm_pkg::*;
#(
    parameter int N_BANK = 8,
    parameter int ROW_W  = 15,
    parameter int A10    = 10,
    parameter int T_RCD  = 5,
    parameter int T_RP   = 5,
    parameter int T_RC   = 22,
    parameter int T_RFC  = 79
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel,
    input  logic                      cke,
    input  cmd_e                      cmd,
    input  logic [$clog2(N_BANK)-1:0] ba,
    input  logic [ROW_W-1:0]          addr,
    output rank_err_t                 err
);
    localparam int BAW   = $clog2(N_BANK);
    localparam int RCD_W = $clog2(T_RCD + 1);
    localparam int RP_W  = $clog2(T_RP + 1);
    localparam int RC_W  = $clog2(T_RC + 1);
    localparam int RFC_W = $clog2(T_RFC + 1);
    localparam logic [RCD_W-1:0] RCD_LD = RCD_W'(T_RCD - 1);
    localparam logic [RP_W-1:0]  RP_LD  = RP_W'(T_RP - 1);
    localparam logic [RC_W-1:0]  RC_LD  = RC_W'(T_RC - 1);
    localparam logic [RFC_W-1:0] RFC_LD = RFC_W'(T_RFC - 1);

    logic [N_BANK-1:0] open_q;
    logic [ROW_W-1:0]  row_q   [N_BANK];
    logic [RCD_W-1:0]  rcd_cnt [N_BANK];
    logic [RP_W-1:0]   rp_cnt  [N_BANK];
    logic [RC_W-1:0]   rc_cnt  [N_BANK];
    logic [RFC_W-1:0]  rfc_cnt;

    logic live, acc, a10;
    logic [BAW-1:0] b;

    always_comb begin
        live = sel && (cmd != CMD_NOP);
        acc  = live && cke;
        a10  = addr[A10];
        b    = ba;
        err.power      = live && !cke;
        err.act_open   = acc && (cmd == CMD_ACT) && open_q[b];
        err.acc_closed = acc && is_access(cmd) && !open_q[b];
        err.ref_open   = acc && (cmd == CMD_REF) && (|open_q);
        err.rfc        = acc && (rfc_cnt != '0);
        err.rcd        = acc && is_access(cmd) && open_q[b] && (rcd_cnt[b] != '0);
        err.rp         = acc && (cmd == CMD_ACT) && (rp_cnt[b] != '0);
        err.rc         = acc && (cmd == CMD_ACT) && (rc_cnt[b] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= '0;
            rfc_cnt <= '0;
            for (int i = 0; i < N_BANK; i++) begin
                row_q[i]   <= '0;
                rcd_cnt[i] <= '0;
                rp_cnt[i]  <= '0;
                rc_cnt[i]  <= '0;
            end
        end else begin
            if (rfc_cnt != '0) rfc_cnt <= rfc_cnt - 1'b1;
            for (int i = 0; i < N_BANK; i++) begin
                if (rcd_cnt[i] != '0) rcd_cnt[i] <= rcd_cnt[i] - 1'b1;
                if (rp_cnt[i]  != '0) rp_cnt[i]  <= rp_cnt[i]  - 1'b1;
                if (rc_cnt[i]  != '0) rc_cnt[i]  <= rc_cnt[i]  - 1'b1;
            end
            if (acc) begin
                unique case (cmd)
                    CMD_ACT: begin
                        open_q[b]  <= 1'b1;
                        row_q[b]   <= addr;
                        rcd_cnt[b] <= RCD_LD;
                        rc_cnt[b]  <= RC_LD;
                    end
                    CMD_RD, CMD_WR: begin
                        if (a10) open_q[b] <= 1'b0;
                    end
                    CMD_PRE: begin
                        if (a10) begin
                            open_q <= '0;
                            for (int i = 0; i < N_BANK; i++) rp_cnt[i] <= RP_LD;
                        end else begin
                            open_q[b] <= 1'b0;
                            rp_cnt[b] <= RP_LD;
                        end
                    end
                    CMD_REF: rfc_cnt <= RFC_LD;
                    default: ;
                endcase
            end
        end
    end

    p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd == CMD_ACT) |=> open_q[$past(ba)]);

    p_pre_all_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd == CMD_PRE && addr[A10]) |=> (open_q == '0));

    p_autopre_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && is_access(cmd) && addr[A10]) |=> !open_q[$past(ba)]);

    p_power_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (live && !cke) |=> $stable(open_q));

    generate
        for (genvar g = 0; g < N_BANK; g++) begin : g_row_chk
            p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
                !(acc && cmd == CMD_ACT && ba == BAW'(g)) |=> $stable(row_q[g]));
        end
    endgenerate
endmodule

// File: rtl/rbm_viol_latch.sv
module rbm_viol_latch
    import rbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [NCODE-1:1] hits,
    output logic             viol_flag,
    output viol_e            viol_code
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            viol_flag <= 1'b0;
            viol_code <= V_NONE;
        end else if (!viol_flag && (|hits)) begin
            viol_flag <= 1'b1;
            viol_code <= pick_first(hits);
        end
    end

    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !clr) |=> (viol_flag && $stable(viol_code)));

    p_clear_r12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!viol_flag && viol_code == V_NONE));
endmodule

// File: rtl/rank_bank_monitor.sv
module rank_bank_monitor
    import rbm_pkg::*;
#(
    parameter int N_RANK = 2,
    parameter int N_BANK = 8,
    parameter int ROW_W  = 15,
    parameter int T_RCD  = 5,
    parameter int T_RP   = 5,
    parameter int T_RC   = 22,
    parameter int T_RFC  = 79
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        viol_clr,
    input  logic [1:0]  cs_n,
    input  logic [1:0]  cke,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic [2:0]  ba,
    input  logic [14:0] addr,
    output logic        viol_flag,
    output logic [3:0]  viol_code
);
    cmd_e              cmd;
    logic [N_RANK-1:0] rank_sel;
    logic              multi_cs;
    rank_err_t         errs [N_RANK];
    rank_err_t         any_err;
    logic [NCODE-1:1]  hits;
    viol_e             code_q;

    rbm_cmd_decode #(.N_RANK(N_RANK)) u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cmd      (cmd),
        .rank_sel (rank_sel),
        .multi_cs (multi_cs)
    );

    generate
        for (genvar r = 0; r < N_RANK; r++) begin : g_rank
            rbm_rank_tracker #(
                .N_BANK (N_BANK),
                .ROW_W  (ROW_W),
                .T_RCD  (T_RCD),
                .T_RP   (T_RP),
                .T_RC   (T_RC),
                .T_RFC  (T_RFC)
            ) u_trk (
                .clk  (clk),
                .rst  (rst),
                .sel  (rank_sel[r]),
                .cke  (cke[r]),
                .cmd  (cmd),
                .ba   (ba),
                .addr (addr),
                .err  (errs[r])
            );
        end
    endgenerate

    always_comb begin
        any_err = '0;
        for (int r = 0; r < N_RANK; r++) any_err = any_err | errs[r];
        hits = '0;
        hits[V_MULTI_CS]   = multi_cs;
        hits[V_POWER]      = any_err.power;
        hits[V_ACT_OPEN]   = any_err.act_open;
        hits[V_ACC_CLOSED] = any_err.acc_closed;
        hits[V_REF_OPEN]   = any_err.ref_open;
        hits[V_RFC]        = any_err.rfc;
        hits[V_RCD]        = any_err.rcd;
        hits[V_RP]         = any_err.rp;
        hits[V_RC]         = any_err.rc;
    end

    rbm_viol_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .clr       (viol_clr),
        .hits      (hits),
        .viol_flag (viol_flag),
        .viol_code (code_q)
    );

    assign viol_code = code_q;

    p_multi_cs_r10: assert property (@(posedge clk) disable iff (rst)
        ($countones(~cs_n) > 1 && !viol_clr && !viol_flag) |=> (viol_code == 4'd1));
endmodule

// File: tb/rank_bank_monitor_tb_top.sv
module rank_bank_monitor_tb_top;
    localparam time CLK_PERIOD = 10ns;

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        viol_clr = 1'b0;
    logic [1:0]  cs_n = 2'b11;
    logic [1:0]  cke = 2'b11;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [14:0] addr = '0;
    logic        viol_flag;
    logic [3:0]  viol_code;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rank_bank_monitor dut_i (
        .clk (clk), .rst (rst), .viol_clr (viol_clr),
        .cs_n (cs_n), .cke (cke), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .viol_flag (viol_flag), .viol_code (viol_code)
    );

    task automatic check(input string req, input logic ef, input logic [3:0] ec);
        n_chk++;
        if (viol_flag !== ef || viol_code !== ec) begin
            n_bad++;
            $display("FAIL %s: flag/code got %0b/%0d expected %0b/%0d",
                     req, viol_flag, viol_code, ef, ec);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_clr();
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
    endtask

    task automatic nops(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raw(input logic [1:0] cs, input logic [2:0] c,
                       input logic [2:0] b, input logic [14:0] a);
        cs_n = cs;
        {ras_n, cas_n, we_n} = c;
        ba = b;
        addr = a;
        @(negedge clk);
        cs_n = 2'b11;
        {ras_n, cas_n, we_n} = C_NOP;
    endtask

    task automatic issue(input int rank, input logic [2:0] c,
                         input logic [2:0] b, input logic [14:0] a);
        raw(rank == 0 ? 2'b10 : 2'b01, c, b, a);
    endtask

    localparam logic [14:0] A10 = 15'h0400;

    task automatic t_reset();
        do_reset();
        check("R1 reset state", 1'b0, 4'd0);
    endtask

    task automatic t_rcd();
        do_reset();
        issue(0, C_ACT, 3'd1, 15'h0123);
        nops(3);
        issue(0, C_RD, 3'd1, 15'h0000);
        check("R6 read one cycle early", 1'b1, 4'd7);
        pulse_clr();
        check("R12 clear", 1'b0, 4'd0);
        issue(0, C_ACT, 3'd2, 15'h0055);
        nops(4);
        issue(0, C_WR, 3'd2, 15'h0000);
        check("R6 write at limit", 1'b0, 4'd0);
    endtask

    task automatic t_state();
        do_reset();
        issue(0, C_RD, 3'd3, 15'h0000);
        check("R3 read closed bank", 1'b1, 4'd4);
        do_reset();
        issue(0, C_ACT, 3'd0, 15'h0001);
        nops(30);
        issue(0, C_ACT, 3'd0, 15'h0002);
        check("R3 activate open bank", 1'b1, 4'd3);
        issue(0, C_RD, 3'd5, 15'h0000);
        check("R12 first code kept", 1'b1, 4'd3);
        do_reset();
        issue(0, C_ACT, 3'd0, 15'h0001);
        nops(25);
        issue(0, C_REF, 3'd0, 15'h0000);
        check("R3 refresh with open bank", 1'b1, 4'd5);
    endtask

    task automatic t_precharge();
        do_reset();
        issue(0, C_ACT, 3'd0, 15'h0011);
        issue(0, C_ACT, 3'd4, 15'h0022);
        nops(25);
        issue(0, C_PRE, 3'd0, A10);
        nops(10);
        issue(0, C_REF, 3'd0, 15'h0000);
        check("R4 precharge all then refresh", 1'b0, 4'd0);
        issue(0, C_RD, 3'd4, 15'h0000);
        check("R4 bank4 closed by precharge all", 1'b1, 4'd4);
        do_reset();
        issue(0, C_ACT, 3'd0, 15'h0011);
        issue(0, C_ACT, 3'd1, 15'h0022);
        nops(25);
        issue(0, C_PRE, 3'd0, 15'h0000);
        nops(3);
        issue(0, C_RD, 3'd1, 15'h0000);
        check("R4 single precharge keeps bank1 open", 1'b0, 4'd0);
        issue(0, C_RD, 3'd0, 15'h0000);
        check("R4 single precharge closed bank0", 1'b1, 4'd4);
    endtask

    task automatic t_autopre();
        do_reset();
        issue(0, C_ACT, 3'd6, 15'h0777);
        nops(4);
        issue(0, C_RD, 3'd6, A10);
        check("R5 read with auto precharge", 1'b0, 4'd0);
        nops(3);
        issue(0, C_WR, 3'd6, 15'h0000);
        check("R5 bank closed after auto precharge", 1'b1, 4'd4);
    endtask

    task automatic t_rp_rc();
        do_reset();
        issue(0, C_ACT, 3'd2, 15'h0001);
        nops(25);
        issue(0, C_PRE, 3'd2, 15'h0000);
        nops(2);
        issue(0, C_ACT, 3'd2, 15'h0001);
        check("R7 activate inside recovery", 1'b1, 4'd8);
        do_reset();
        issue(0, C_ACT, 3'd3, 15'h0001);
        nops(5);
        issue(0, C_PRE, 3'd3, 15'h0000);
        nops(5);
        issue(0, C_ACT, 3'd3, 15'h0001);
        check("R8 activate-to-activate too close", 1'b1, 4'd9);
        do_reset();
        issue(0, C_ACT, 3'd0, 15'h0001);
        nops(5);
        issue(0, C_ACT, 3'd0, 15'h0002);
        check("R12 priority open-bank over spacing", 1'b1, 4'd3);
    endtask

    task automatic t_rfc();
        do_reset();
        issue(0, C_REF, 3'd0, 15'h0000);
        nops(10);
        issue(0, C_ACT, 3'd0, 15'h0001);
        check("R9 command inside refresh recovery", 1'b1, 4'd6);
        do_reset();
        issue(0, C_REF, 3'd0, 15'h0000);
        nops(78);
        issue(0, C_ACT, 3'd0, 15'h0001);
        check("R9 command at refresh limit", 1'b0, 4'd0);
    endtask

    task automatic t_ranks_cs();
        do_reset();
        issue(1, C_ACT, 3'd0, 15'h0001);
        nops(6);
        issue(0, C_RD, 3'd0, 15'h0000);
        check("R13 rank0 unaffected by rank1 activate", 1'b1, 4'd4);
        do_reset();
        issue(0, C_ACT, 3'd0, 15'h0001);
        issue(1, C_ACT, 3'd0, 15'h0001);
        check("R13 independent spacing per rank", 1'b0, 4'd0);
        do_reset();
        raw(2'b11, C_ACT, 3'd5, 15'h0001);
        nops(6);
        check("R2 deselected command no flag", 1'b0, 4'd0);
        issue(0, C_RD, 3'd5, 15'h0000);
        check("R2 deselected activate ignored", 1'b1, 4'd4);
        do_reset();
        raw(2'b00, C_ACT, 3'd0, 15'h0001);
        check("R10 both chip selects low", 1'b1, 4'd1);
        pulse_clr();
        nops(6);
        issue(0, C_RD, 3'd0, 15'h0000);
        check("R10 dual-select command not applied", 1'b1, 4'd4);
    endtask

    task automatic t_power();
        do_reset();
        cke = 2'b10;
        issue(0, C_NOP, 3'd0, 15'h0000);
        check("R11 no-op with clock enable low", 1'b0, 4'd0);
        issue(1, C_ACT, 3'd0, 15'h0001);
        check("R11 other rank still active", 1'b0, 4'd0);
        issue(0, C_ACT, 3'd1, 15'h0001);
        check("R11 command with clock enable low", 1'b1, 4'd2);
        cke = 2'b11;
        pulse_clr();
        nops(6);
        issue(0, C_RD, 3'd1, 15'h0000);
        check("R11 command not applied", 1'b1, 4'd4);
    endtask

    task automatic t_clr_same_cycle();
        do_reset();
        viol_clr = 1'b1;
        issue(0, C_RD, 3'd7, 15'h0000);
        viol_clr = 1'b0;
        check("R12 clear drops same-cycle violation", 1'b0, 4'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_rcd();
        t_state();
        t_precharge();
        t_autopre();
        t_rp_rc();
        t_rfc();
        t_ranks_cs();
        t_power();
        t_clr_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule